// File: doc/BRIEF.md
# RTC Tick Source Selector and Divider

This block produces the two timing strobes of a real-time-clock domain, a fast tick and a slow tick, from candidate oscillator sources. All of it runs on one system clock. Each source reaches it as a one-cycle tick strobe:
- a slow internal RC oscillator;
- a 32 kHz crystal;
- an 8 MHz internal oscillator;
- a main crystal.

The block holds a 32-bit configuration word. Each field of that word selects a source, sets a divider ratio or gates a tick. The word is written whole and is always readable.

The fast tick comes from either the main crystal divided by four or the 8 MHz tick passed straight through. The slow tick comes from the RC tick, the 32 kHz tick, or a post-divided 8 MHz tick. The post-divider can be bypassed, and a kill bit silences the 8 MHz path altogether. Further gated copies of the 8 MHz, divided-8 MHz and 32 kHz ticks go to the digital core. So does the output of a small auxiliary 8 MHz divider.

A new source selection is taken up only once the source in use has produced its next tick, so no strobe is cut or doubled. A write that changes a selection raises a busy flag for a settling time given in microseconds. The parameter `CYC_PER_US` converts that time to system clocks. Every tick output is registered, so it appears one clock after the input tick that causes it.

Top module: `rtc_clk_sel`

## Requirements
- R1: After reset the configuration word reads 0x0000_2210 and busy is low. Every bit reads back as last written, including bits with no function (bits 28:15, 11, 3:0).
- R2: Fast select is bit 29. Value 0 gives one fast tick per four main-crystal ticks. Value 1 gives one fast tick per (unkilled) 8 MHz tick.
- R3: Slow select is bits 31:30. The codes are: 0 = RC tick, 1 = 32 kHz tick, 2 = divided 8 MHz tick, 3 = no slow tick at all.
- R4: The post-divider ratio field is bits 5:4. The codes are 00 = /128, 01 = /256, 10 = /512, 11 = /1024. A write that changes this field restarts its count from zero. The divided tick fires on the tick that brings the count to ratio minus one.
- R5: When bit 7 is 1, the divided 8 MHz tick equals the undivided 8 MHz tick.
- R6: When bit 6 is 1, no pulse leaves the 8 MHz path. This covers the direct copy, the divided copy, the auxiliary divider and any selection fed by them.
- R7: Bits 14:12 hold a value N. The auxiliary divider emits one `dig_aux_tick_o` per N+1 unkilled 8 MHz ticks. A change of N restarts its count.
- R8: Bits 10, 9 and 8 gate the 8 MHz, divided-8 MHz and 32 kHz ticks onto `dig_osc_tick_o`, `dig_osc_div_tick_o` and `dig_x32k_tick_o`.
- R9: A changed selection takes effect right after the next tick of the source in use. That tick is still output. The change is immediate if the source in use cannot tick (code 3, or a killed 8 MHz path).
- R10: A write that changes the fast select holds busy high for 3·CYC_PER_US clocks. A write that changes the slow select holds it high for 300·CYC_PER_US clocks. When windows overlap, the longer remaining window wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rc_tick_i | input | 1 | Slow RC oscillator tick strobe |
| x32k_tick_i | input | 1 | 32 kHz crystal tick strobe |
| osc8m_tick_i | input | 1 | 8 MHz oscillator tick strobe |
| xtal_tick_i | input | 1 | Main crystal tick strobe |
| cfg_we_i | input | 1 | Write strobe for the configuration word |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Current configuration word |
| fast_tick_o | output | 1 | Selected fast RTC tick |
| slow_tick_o | output | 1 | Selected slow RTC tick |
| dig_osc_tick_o | output | 1 | Gated 8 MHz tick for the digital core |
| dig_osc_div_tick_o | output | 1 | Gated divided-8 MHz tick for the digital core |
| dig_x32k_tick_o | output | 1 | Gated 32 kHz tick for the digital core |
| dig_aux_tick_o | output | 1 | Auxiliary 8 MHz divider tick |
| busy_o | output | 1 | Settling window after a select change |

## Verification
The hardest situation to reach is a pending selection. The register already holds the new code, but the old source still drives the output because it has not ticked yet. The stimulus writes the new select and then feeds many ticks of only the new source, and checks that none of them appear. It then feeds exactly one tick of the old source and checks that this tick is output. The divider restart is reached the same way: a partial count is run first, then the ratio is rewritten, and 255 ticks must give no output where a non-restarting counter would give one.

// File: rtl/rtc_clk_pkg.sv
package rtc_clk_pkg;
    localparam int CFG_W       = 32;
    localparam int SLOW_LO     = 30;
    localparam int FAST_BIT    = 29;
    localparam int AUX_LO      = 12;
    localparam int AUX_W       = 3;
    localparam int DIG_OSC_BIT = 10;
    localparam int DIG_DIV_BIT = 9;
    localparam int DIG_32K_BIT = 8;
    localparam int BYPASS_BIT  = 7;
    localparam int KILL_BIT    = 6;
    localparam int PDIV_LO     = 4;
    localparam int PDIV_SEL_W  = 2;
    localparam int PDIV_BASE_LOG = 7;
    localparam int PDIV_W      = PDIV_BASE_LOG + (1 << PDIV_SEL_W) - 1;
    localparam logic [CFG_W-1:0] CFG_RESET = 32'h0000_2210;

    typedef enum logic [1:0] {
        SLOW_RC      = 2'd0,
        SLOW_X32K    = 2'd1,
        SLOW_OSC_DIV = 2'd2,
        SLOW_NONE    = 2'd3
    } slow_src_e;
endpackage

// File: rtl/rtc_tick_div.sv
module rtc_tick_div #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         restart_i,
    input  logic [W-1:0] limit_i,
    output logic         pulse_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        pulse_o = tick_i && !restart_i && (st_q.cnt >= limit_i);
        if (restart_i) begin
            st_d.cnt = '0;
        end else if (tick_i) begin
            st_d.cnt = pulse_o ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !restart_i) |=> $stable(st_q.cnt));

    // R4
    restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (st_q.cnt == '0));
endmodule

// File: rtl/rtc_src_switch.sv
module rtc_src_switch #(
    parameter int N  = 4,
    parameter int SW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  tick_i,
    input  logic [N-1:0]  live_i,
    input  logic [SW-1:0] want_i,
    output logic          tick_o,
    output logic [SW-1:0] act_o
);
    typedef struct packed {
        logic [SW-1:0] act;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        tick_o = tick_i[st_q.act];
        if ((want_i != st_q.act) && (tick_o || !live_i[st_q.act])) begin
            st_d.act = want_i;
        end
    end

    assign act_o = st_q.act;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R9
    no_early_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i[st_q.act] && live_i[st_q.act]) |=> $stable(st_q.act));
endmodule

// File: rtl/rtc_settle_timer.sv
module rtc_settle_timer #(
    parameter int CYC_PER_US = 50,
    parameter int FAST_US    = 3,
    parameter int SLOW_US    = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fast_chg_i,
    input  logic slow_chg_i,
    output logic busy_o
);
    localparam int FAST_CYC = FAST_US * CYC_PER_US;
    localparam int SLOW_CYC = SLOW_US * CYC_PER_US;
    localparam int MAX_CYC  = (SLOW_CYC > FAST_CYC) ? SLOW_CYC : FAST_CYC;
    localparam int CW       = $clog2(MAX_CYC + 1);
    localparam logic [CW-1:0] FAST_V = CW'(FAST_CYC);
    localparam logic [CW-1:0] SLOW_V = CW'(SLOW_CYC);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic [CW-1:0] load_v;

    always_comb begin
        st_d   = st_q;
        load_v = '0;
        if (fast_chg_i && FAST_V > load_v) load_v = FAST_V;
        if (slow_chg_i && SLOW_V > load_v) load_v = SLOW_V;
        if (st_q.cnt != '0) st_d.cnt = st_q.cnt - 1'b1;
        if (load_v > st_d.cnt) st_d.cnt = load_v;
    end

    assign busy_o = (st_q.cnt != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R10
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_chg_i || slow_chg_i) |=> busy_o);

    // R10
    busy_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !fast_chg_i && !slow_chg_i) |=> (st_q.cnt == $past(st_q.cnt) - 1'b1));
endmodule

// File: rtl/rtc_clk_sel.sv
module rtc_clk_sel
    import rtc_clk_pkg::*;
#(
    parameter int CYC_PER_US = 50
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rc_tick_i,
    input  logic        x32k_tick_i,
    input  logic        osc8m_tick_i,
    input  logic        xtal_tick_i,
    input  logic        cfg_we_i,
    input  logic [31:0] cfg_wdata_i,
    output logic [31:0] cfg_rdata_o,
    output logic        fast_tick_o,
    output logic        slow_tick_o,
    output logic        dig_osc_tick_o,
    output logic        dig_osc_div_tick_o,
    output logic        dig_x32k_tick_o,
    output logic        dig_aux_tick_o,
    output logic        busy_o
);
    typedef struct packed {
        logic [CFG_W-1:0] cfg;
        logic fast;
        logic slow;
        logic dig_osc;
        logic dig_div;
        logic dig_32k;
        logic aux;
    } st_t;

    st_t st_d, st_q;

    logic              slow_chg, fast_chg, pdiv_chg, aux_chg;
    logic              osc_live, osc_ok, osc_div, pdiv_pulse, xdiv_pulse, aux_pulse;
    logic [PDIV_W:0]   pdiv_one_sh;
    logic [PDIV_W-1:0] pdiv_lim;
    logic              fast_sel_tick, slow_sel_tick;
    logic              fast_act;
    logic [1:0]        slow_act;

    always_comb begin
        slow_chg = cfg_we_i && (cfg_wdata_i[SLOW_LO +: 2] != st_q.cfg[SLOW_LO +: 2]);
        fast_chg = cfg_we_i && (cfg_wdata_i[FAST_BIT] != st_q.cfg[FAST_BIT]);
        pdiv_chg = cfg_we_i && (cfg_wdata_i[PDIV_LO +: PDIV_SEL_W] != st_q.cfg[PDIV_LO +: PDIV_SEL_W]);
        aux_chg  = cfg_we_i && (cfg_wdata_i[AUX_LO +: AUX_W] != st_q.cfg[AUX_LO +: AUX_W]);

        osc_live = !st_q.cfg[KILL_BIT];
        osc_ok   = osc8m_tick_i && osc_live;

        pdiv_one_sh = (PDIV_W+1)'(1) << (PDIV_BASE_LOG + int'(st_q.cfg[PDIV_LO +: PDIV_SEL_W]));
        pdiv_lim    = PDIV_W'(pdiv_one_sh - 1'b1);

        osc_div = st_q.cfg[BYPASS_BIT] ? osc_ok : pdiv_pulse;
    end

    rtc_tick_div #(.W(PDIV_W)) u_post_div (
        .clk(clk), .rst_n(rst_n), .tick_i(osc_ok), .restart_i(pdiv_chg),
        .limit_i(pdiv_lim), .pulse_o(pdiv_pulse)
    );

    rtc_tick_div #(.W(2)) u_xtal_div (
        .clk(clk), .rst_n(rst_n), .tick_i(xtal_tick_i), .restart_i(1'b0),
        .limit_i(2'd3), .pulse_o(xdiv_pulse)
    );

    rtc_tick_div #(.W(AUX_W)) u_aux_div (
        .clk(clk), .rst_n(rst_n), .tick_i(osc_ok), .restart_i(aux_chg),
        .limit_i(st_q.cfg[AUX_LO +: AUX_W]), .pulse_o(aux_pulse)
    );

    rtc_src_switch #(.N(2)) u_fast_sw (
        .clk(clk), .rst_n(rst_n),
        .tick_i({osc_ok, xdiv_pulse}),
        .live_i({osc_live, 1'b1}),
        .want_i(st_q.cfg[FAST_BIT]),
        .tick_o(fast_sel_tick), .act_o(fast_act)
    );

    rtc_src_switch #(.N(4)) u_slow_sw (
        .clk(clk), .rst_n(rst_n),
        .tick_i({1'b0, osc_div, x32k_tick_i, rc_tick_i}),
        .live_i({1'b0, osc_live, 1'b1, 1'b1}),
        .want_i(st_q.cfg[SLOW_LO +: 2]),
        .tick_o(slow_sel_tick), .act_o(slow_act)
    );

    rtc_settle_timer #(.CYC_PER_US(CYC_PER_US)) u_settle (
        .clk(clk), .rst_n(rst_n), .fast_chg_i(fast_chg), .slow_chg_i(slow_chg),
        .busy_o(busy_o)
    );

    always_comb begin
        st_d         = st_q;
        if (cfg_we_i) st_d.cfg = cfg_wdata_i;
        st_d.fast    = fast_sel_tick;
        st_d.slow    = slow_sel_tick;
        st_d.dig_osc = osc_ok  && st_q.cfg[DIG_OSC_BIT];
        st_d.dig_div = osc_div && st_q.cfg[DIG_DIV_BIT];
        st_d.dig_32k = x32k_tick_i && st_q.cfg[DIG_32K_BIT];
        st_d.aux     = aux_pulse;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.cfg <= CFG_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_rdata_o        = st_q.cfg;
    assign fast_tick_o        = st_q.fast;
    assign slow_tick_o        = st_q.slow;
    assign dig_osc_tick_o     = st_q.dig_osc;
    assign dig_osc_div_tick_o = st_q.dig_div;
    assign dig_x32k_tick_o    = st_q.dig_32k;
    assign dig_aux_tick_o     = st_q.aux;

    // R6
    kill_silences_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cfg[KILL_BIT] |=> (!dig_osc_tick_o && !dig_osc_div_tick_o && !dig_aux_tick_o));

    // R6
    kill_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_act && st_q.cfg[KILL_BIT]) |=> !fast_tick_o);

    // R3
    slow_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slow_act == SLOW_NONE) |=> !slow_tick_o);

    // R1
    cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we_i |=> (cfg_rdata_o == $past(cfg_wdata_i)));
endmodule

// File: tb/rtc_clk_sel_test.sv
module rtc_clk_sel_test;
    localparam int CPU = 50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rc = 1'b0, x32 = 1'b0, osc = 1'b0, xt = 1'b0;
    logic we = 1'b0;
    logic [31:0] wd = '0;
    logic [31:0] rd;
    logic ft, st, d8, dd, d32, da, busy;

    always #10 clk = ~clk;

    rtc_clk_sel #(.CYC_PER_US(CPU)) uut (
        .clk(clk), .rst_n(rst_n),
        .rc_tick_i(rc), .x32k_tick_i(x32), .osc8m_tick_i(osc), .xtal_tick_i(xt),
        .cfg_we_i(we), .cfg_wdata_i(wd), .cfg_rdata_o(rd),
        .fast_tick_o(ft), .slow_tick_o(st), .dig_osc_tick_o(d8),
        .dig_osc_div_tick_o(dd), .dig_x32k_tick_o(d32), .dig_aux_tick_o(da),
        .busy_o(busy)
    );

    // counter index: 0 fast, 1 slow, 2 dig_osc, 3 dig_div, 4 dig_32k, 5 aux, 6 busy cycles
    int n_run = 0;
    int n_fail = 0;
    int cnt[7];
    int base[7];
    string tq[$];
    int iq[$];
    int eq[$];

    task automatic chk(string tag, longint got, longint exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // monitor: counts output strobes, pops expected items and compares
    always @(negedge clk) begin
        if (rst_n) begin
            cnt[0] += int'(ft);  cnt[1] += int'(st);  cnt[2] += int'(d8);
            cnt[3] += int'(dd);  cnt[4] += int'(d32); cnt[5] += int'(da);
            cnt[6] += int'(busy);
        end
        while (tq.size() > 0) begin
            string t;
            int    i;
            int    e;
            t = tq.pop_front();
            i = iq.pop_front();
            e = eq.pop_front();
            chk(t, cnt[i], e);
        end
    end

    task automatic mark();
        base = cnt;
    endtask

    task automatic expect_d(string tag, int idx, int delta);
        tq.push_back(tag);
        iq.push_back(idx);
        eq.push_back(base[idx] + delta);
    endtask

    task automatic set_tick(int idx, logic v);
        case (idx)
            0: rc  = v;
            1: x32 = v;
            2: osc = v;
            default: xt = v;
        endcase
    endtask

    // idx: 0 rc, 1 x32k, 2 osc8m, 3 xtal
    task automatic ticks(int idx, int n);
        set_tick(idx, 1'b1);
        repeat (n) @(posedge clk);
        #1;
        set_tick(idx, 1'b0);
        repeat (3) @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [31:0] v);
        we = 1'b1;
        wd = v;
        @(posedge clk);
        #1;
        we = 1'b0;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int k = 0; k < 7; k++) cnt[k] = 0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(posedge clk);
        #1;

        // R1 reset state
        chk("R1 reset cfg", rd, 32'h0000_2210);
        chk("R1 reset busy", busy, 0);

        // R2 fast from xtal/4
        mark(); ticks(3, 40);
        expect_d("R2 xtal div4", 0, 10);

        // R3 slow from RC
        mark(); ticks(0, 7);
        expect_d("R3 slow rc", 1, 7);

        // R4 /256 default, R7 aux ratio 3, R8 gates
        mark(); ticks(2, 768);
        expect_d("R4 div256", 3, 3);
        expect_d("R7 aux ratio3", 5, 256);
        expect_d("R8 dig_osc gated off", 2, 0);
        expect_d("R9 slow stays rc", 1, 0);

        // R10 slow change busy, R4 /128, R9 pending switch
        mark(); wr(32'h8000_2200);
        chk("R1 readback", rd, 32'h8000_2200);
        repeat (15010) @(posedge clk);
        #1;
        expect_d("R10 slow busy window", 6, 15000);
        mark(); ticks(2, 384);
        expect_d("R9 new source held off", 1, 0);
        expect_d("R4 div128", 3, 3);
        expect_d("R7 aux ratio3 again", 5, 128);
        mark(); ticks(0, 1);
        expect_d("R9 old source last tick", 1, 1);
        mark(); ticks(2, 384);
        expect_d("R3 slow from div8m", 1, 3);

        // R4 restart on ratio change
        ticks(2, 100);
        wr(32'h8000_2210);
        mark(); ticks(2, 255);
        expect_d("R4 restart no early pulse", 3, 0);
        mark(); ticks(2, 1);
        expect_d("R4 restart pulse at 256", 3, 1);
        expect_d("R3 slow follows div", 1, 1);

        // R4 /1024 and /512, R7 aux field 0 and 7
        wr(32'h8000_0230);
        mark(); ticks(2, 1024);
        expect_d("R4 div1024", 3, 1);
        expect_d("R7 aux ratio1", 5, 1024);
        wr(32'h8000_7220);
        mark(); ticks(2, 1024);
        expect_d("R4 div512", 3, 2);
        expect_d("R7 aux ratio8", 5, 128);

        // R5 bypass, R8 dig_osc on
        wr(32'h8000_76A0);
        mark(); ticks(2, 50);
        expect_d("R5 bypass div out", 3, 50);
        expect_d("R5 bypass slow", 1, 50);
        expect_d("R8 dig_osc on", 2, 50);

        // R6 kill
        wr(32'h8000_76E0);
        mark(); ticks(2, 50);
        expect_d("R6 kill dig_osc", 2, 0);
        expect_d("R6 kill div", 3, 0);
        expect_d("R6 kill aux", 5, 0);
        expect_d("R6 kill slow", 1, 0);

        // R10 fast change busy, R2 fast from 8M, R9 fast pending
        mark(); wr(32'hA000_76A0);
        repeat (160) @(posedge clk);
        #1;
        expect_d("R10 fast busy window", 6, 150);
        mark(); ticks(2, 20);
        expect_d("R9 fast held on xtal", 0, 0);
        expect_d("R8 dig_osc count", 2, 20);
        mark(); ticks(3, 4);
        expect_d("R9 fast old last tick", 0, 1);
        mark(); ticks(2, 20);
        expect_d("R2 fast from osc8m", 0, 20);

        // R3 reserved code
        wr(32'hE000_76A0);
        mark(); ticks(2, 1);
        expect_d("R9 switch to reserved", 1, 1);
        mark(); ticks(0, 5); ticks(1, 5); ticks(2, 5);
        expect_d("R3 reserved no slow", 1, 0);
        expect_d("R8 dig_32k gated off", 4, 0);

        // R3 32k source, R9 immediate from reserved, R8 dig_32k on
        wr(32'h6000_77A0);
        mark(); ticks(1, 6);
        expect_d("R3 slow x32k", 1, 6);
        expect_d("R8 dig_32k on", 4, 6);

        // R1 unused bits read back
        wr(32'h7FFF_FFAF);
        chk("R1 unused bits readback", rd, 32'h7FFF_FFAF);
        mark(); ticks(1, 2);
        expect_d("R1 fields intact", 1, 2);

        repeat (3) @(posedge clk);
        #1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule